// File: doc/BRIEF.md
# AHB-Lite to APB4 Bridge with Byte-Lane Strobes

This block sits between a 32-bit AHB-Lite bus and a single APB4 peripheral. It takes one AHB transfer at a time, runs it on the peripheral side as a two-phase APB transfer, and holds the AHB side waiting until the peripheral signals completion. On the AHB side the active bytes are only implied by the transfer size and the two low address bits. The peripheral side needs them as an explicit per-lane byte-write-enable mask. The bridge produces that mask, so a byte or halfword write changes only the bytes it addresses.

The bridge registers the address-phase controls and latches the write data in the first data-phase cycle. It then drives the setup phase and the access phase. It also reports errors: a peripheral error, or a transfer size the 32-bit path cannot carry, becomes a two-cycle AHB error response. A burst is simply a run of single transfers, one after another.

Top module: `ahb_strobe_bridge`

## Requirements
- R1: A word write (`up_size` = 3'b010) drives `dn_byte_en` = 4'b1111 for the whole peripheral transfer.
- R2: A halfword write (`up_size` = 3'b001) enables two adjacent lanes starting at the byte offset `up_addr[1:0]`: offset 0 gives 4'b0011 and offset 2 gives 4'b1100.
- R3: A byte write (`up_size` = 3'b000) enables one lane only, bit `up_addr[1:0]` of `dn_byte_en`. For example, offset 1 gives 4'b0010 and offset 3 gives 4'b1000.
- R4: On a read, `dn_byte_en` is 4'b0000 and `dn_write` is 0. The full 32-bit `dn_rdata` word sampled on completion is returned unchanged on `up_rdata`.
- R5: A transfer is accepted only when `up_sel`=1, `up_trans[1]`=1 (NONSEQ 2'b10 or SEQ 2'b11) and `up_ready_in`=1. IDLE (2'b00), BUSY (2'b01) and cycles with `up_ready_in`=0 start no peripheral access.
- R6: Each peripheral transfer is one setup cycle (`dn_sel`=1, `dn_enable`=0) followed by access cycles (`dn_enable`=1) that last until `dn_ready`=1. `up_ready_out` stays 0 while `dn_sel` is 1. `up_ready_out` is 1 and `up_resp` is 0 after reset.
- R7: `dn_wdata` equals `up_wdata` as sampled in the first data-phase cycle, with all four lanes passed through. It stays stable even if the bus data changes afterwards.
- R8: If `dn_err`=1 when `dn_ready` completes the access, the bridge gives a two-cycle error: `up_resp`=1 with `up_ready_out`=0, then `up_resp`=1 with `up_ready_out`=1.
- R9: A size above 3'b010 gets the same two-cycle error response, and no peripheral access is started.
- R10: Address, size and direction are registered at acceptance. The mask and `dn_addr` come from the registered values, so later changes on `up_addr`/`up_size` have no effect on the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_sel | input | 1 | AHB slave select |
| up_trans | input | 2 | AHB transfer type |
| up_addr | input | ADDR_W | AHB address |
| up_size | input | 3 | AHB transfer size |
| up_write | input | 1 | AHB direction, 1 = write |
| up_wdata | input | DATA_W | AHB write data |
| up_ready_in | input | 1 | AHB bus ready (end of previous data phase) |
| up_ready_out | output | 1 | Bridge ready to the AHB bus |
| up_resp | output | 1 | AHB response, 1 = error |
| up_rdata | output | DATA_W | AHB read data |
| dn_sel | output | 1 | APB peripheral select |
| dn_enable | output | 1 | APB access-phase enable |
| dn_addr | output | ADDR_W | APB address |
| dn_write | output | 1 | APB direction |
| dn_wdata | output | DATA_W | APB write data |
| dn_byte_en | output | DATA_W/8 | Per-lane byte-write-enable mask |
| dn_ready | input | 1 | APB peripheral ready |
| dn_err | input | 1 | APB peripheral error |
| dn_rdata | input | DATA_W | APB read data |

## Verification
The strobe decode is tried with a word write, halfword writes at both aligned offsets and byte writes at all four offsets. This separates a decode that ignores the offset, one that shifts by the wrong amount, and one that gets the lane count wrong for a given size. A byte-sized read shows whether the direction gates the mask, and whether the returned word is cut down to one lane. While a write is in flight the bench puts a different size, a different address and fresh data on the bus, which exposes any use of live bus values instead of the registered ones. Wait-state, peripheral-error and illegal-size transfers separate a correct handshake from one that ends early, drops the error, or reaches the peripheral on a size it should have rejected.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_LATCH  = 3'd1,
    S_SETUP  = 3'd2,
    S_ACCESS = 3'd3,
    S_ERR1   = 3'd4,
    S_ERR2   = 3'd5
  } brg_state_e;
endpackage

// File: rtl/brg_lane_mask.sv
module brg_lane_mask #(
  parameter int LANES = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int MAX_SZ = $clog2(LANES)
) (
  input  logic [2:0]       size,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] mask
);
  int nbytes;

  always_comb begin
    nbytes = (int'(size) <= MAX_SZ) ? (1 << int'(size)) : 0;
    for (int i = 0; i < LANES; i++) begin
      mask[i] = (i >= int'(off)) && (i < int'(off) + nbytes);
    end
  end
endmodule

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       size_ok,
  input  logic       dn_ready,
  input  logic       dn_err,
  output brg_state_e state,
  output logic       sel_q,
  output logic       en_q,
  output logic       ready_q,
  output logic       resp_q
);
  brg_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE, S_ERR2: nxt = accept ? (size_ok ? S_LATCH : S_ERR1) : S_IDLE;
      S_LATCH:        nxt = S_SETUP;
      S_SETUP:        nxt = S_ACCESS;
      S_ACCESS:       if (dn_ready) nxt = dn_err ? S_ERR1 : S_IDLE;
      S_ERR1:         nxt = S_ERR2;
      default:        nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sel_q   <= 1'b0;
      en_q    <= 1'b0;
      ready_q <= 1'b1;
      resp_q  <= 1'b0;
    end else begin
      state   <= nxt;
      sel_q   <= (nxt == S_SETUP) || (nxt == S_ACCESS);
      en_q    <= (nxt == S_ACCESS);
      ready_q <= (nxt == S_IDLE) || (nxt == S_ERR2);
      resp_q  <= (nxt == S_ERR1) || (nxt == S_ERR2);
    end
  end

  // R6: setup phase is always followed by an access phase
  a_r6_setup_then_access: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !en_q) |=> (sel_q && en_q));
  // R6: the AHB side waits while the peripheral is selected
  a_r6_wait_while_busy: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> !ready_q);
  // R8: first error cycle is followed by the completing error cycle
  a_r8_two_cycle_error: assert property (@(posedge clk) disable iff (rst)
    (resp_q && !ready_q) |=> (resp_q && ready_q));
  // R6: access ends only on peripheral ready
  a_r6_access_holds: assert property (@(posedge clk) disable iff (rst)
    (en_q && !dn_ready) |=> en_q);
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_addr,
  input  logic              cap_wdata,
  input  logic              cap_rdata,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [2:0]        up_size,
  input  logic              up_write,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [2:0]        size_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (cap_addr) begin
        addr_q <= up_addr;
        size_q <= up_size;
        wr_q   <= up_write;
      end
      if (cap_wdata) wdata_q <= up_wdata;
      if (cap_rdata) rdata_q <= dn_rdata;
    end
  end
endmodule

// File: rtl/ahb_strobe_bridge.sv
module ahb_strobe_bridge
  import brg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int MAX_SZ = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_sel,
  input  logic [1:0]        up_trans,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [2:0]        up_size,
  input  logic              up_write,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic              up_ready_in,
  output logic              up_ready_out,
  output logic              up_resp,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_sel,
  output logic              dn_enable,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [LANES-1:0]  dn_byte_en,
  input  logic              dn_ready,
  input  logic              dn_err,
  input  logic [DATA_W-1:0] dn_rdata
);
  brg_state_e       state;
  logic             accept, size_ok;
  logic [2:0]       size_q;
  logic             wr_q;
  logic [LANES-1:0] lane_mask;

  assign accept  = up_sel && up_ready_in && ((up_trans == 2'b10) || (up_trans == 2'b11));
  assign size_ok = int'(up_size) <= MAX_SZ;

  brg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .size_ok(size_ok),
    .dn_ready(dn_ready), .dn_err(dn_err), .state(state),
    .sel_q(dn_sel), .en_q(dn_enable), .ready_q(up_ready_out), .resp_q(up_resp)
  );

  brg_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst),
    .cap_addr(accept), .cap_wdata(state == S_LATCH),
    .cap_rdata((state == S_ACCESS) && dn_ready),
    .up_addr(up_addr), .up_size(up_size), .up_write(up_write),
    .up_wdata(up_wdata), .dn_rdata(dn_rdata),
    .addr_q(dn_addr), .size_q(size_q), .wr_q(wr_q),
    .wdata_q(dn_wdata), .rdata_q(up_rdata)
  );

  brg_lane_mask #(.LANES(LANES)) u_mask (
    .size(size_q), .off(dn_addr[OFF_W-1:0]), .mask(lane_mask)
  );

  assign dn_write   = wr_q;
  assign dn_byte_en = wr_q ? lane_mask : '0;

  // R1 R2 R3: lane count on the peripheral matches the registered size
  a_r3_lane_count: assert property (@(posedge clk) disable iff (rst)
    (dn_sel && dn_write) |-> ($countones(dn_byte_en) == (1 << int'(size_q))));
  // R6 R7 R10: strobes, address and data hold across the access phase
  a_r6_stable_in_access: assert property (@(posedge clk) disable iff (rst)
    dn_enable |-> ($stable(dn_byte_en) && $stable(dn_addr) && $stable(dn_wdata)));
  // R9: an unsupported size gives an error and no peripheral select
  a_r9_bad_size_error: assert property (@(posedge clk) disable iff (rst)
    (accept && !size_ok) |=> (up_resp && !dn_sel));
  // R4: a read never carries byte strobes on the peripheral side
  a_r4_read_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (dn_sel && !dn_write) |-> (dn_byte_en == '0));
endmodule

// File: tb/sim_ahb_strobe_bridge.sv
module sim_ahb_strobe_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_sel = 1'b0;
  logic [1:0]  up_trans = 2'b00;
  logic [31:0] up_addr = '0;
  logic [2:0]  up_size = '0;
  logic        up_write = 1'b0;
  logic [31:0] up_wdata = '0;
  logic        up_ready_in, gate = 1'b1;
  logic        up_ready_out, up_resp;
  logic [31:0] up_rdata;
  logic        dn_sel, dn_enable, dn_write;
  logic [31:0] dn_addr, dn_wdata;
  logic [3:0]  dn_byte_en;
  logic        dn_ready = 1'b0, dn_err = 1'b0;
  logic [31:0] dn_rdata = 32'hC0DE_5A17;

  always #10 clk = ~clk;

  assign up_ready_in = up_ready_out & gate;

  ahb_strobe_bridge u0 (
    .clk(clk), .rst(rst), .up_sel(up_sel), .up_trans(up_trans), .up_addr(up_addr),
    .up_size(up_size), .up_write(up_write), .up_wdata(up_wdata),
    .up_ready_in(up_ready_in), .up_ready_out(up_ready_out), .up_resp(up_resp),
    .up_rdata(up_rdata), .dn_sel(dn_sel), .dn_enable(dn_enable), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_byte_en(dn_byte_en),
    .dn_ready(dn_ready), .dn_err(dn_err), .dn_rdata(dn_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // results of the most recent transfer
  bit          r_setup_seen, r_any_sel, r_order_ok, r_rdy_low_ok, r_stable_ok, r_err1_seen;
  bit          r_setup_wr, r_resp_end;
  logic [3:0]  r_strb;
  logic [31:0] r_addr, r_wdata, r_rdata_end;
  int          r_acc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_strb(input logic [2:0] sz, input logic [1:0] off);
    case (sz)
      3'b000:  return 4'b0001 << off;
      3'b001:  return 4'b0011 << off;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [2:0] sz,
                      input logic [31:0] wd, input int waits, input bit err);
    r_setup_seen = 0; r_any_sel = 0; r_order_ok = 1; r_rdy_low_ok = 1; r_stable_ok = 1;
    r_err1_seen = 0; r_resp_end = 0; r_acc = 0; r_strb = 'x; r_wdata = 'x; r_addr = 'x;
    r_rdata_end = 'x; r_setup_wr = 0;
    @(negedge clk);
    up_sel = 1; up_trans = 2'b10; up_addr = addr; up_size = sz; up_write = wr; gate = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) begin
        up_sel = 0; up_trans = 2'b00; up_addr = ~addr;
        up_size = (sz == 3'b000) ? 3'b010 : 3'b000; up_write = ~wr; up_wdata = wd;
      end else begin
        up_wdata = ~wd;
      end
      if (dn_sel) begin
        r_any_sel = 1;
        if (up_ready_out) r_rdy_low_ok = 0;
        if (!dn_enable) begin
          if (r_acc > 0) r_order_ok = 0;
          r_setup_seen = 1; r_strb = dn_byte_en; r_addr = dn_addr; r_setup_wr = dn_write;
        end else begin
          if (!r_setup_seen) r_order_ok = 0;
          if (dn_byte_en !== r_strb || dn_addr !== r_addr) r_stable_ok = 0;
          r_wdata = dn_wdata;
          if (r_acc == waits) begin dn_ready = 1; dn_err = err; end
          else begin dn_ready = 0; dn_err = 0; end
          r_acc++;
        end
      end else begin
        dn_ready = 0; dn_err = 0;
        if (up_resp && !up_ready_out) r_err1_seen = 1;
        if (i > 0 && up_ready_out) begin
          r_resp_end = up_resp; r_rdata_end = up_rdata;
          break;
        end
      end
    end
  endtask

  task automatic t_reset();
    chk("R6 reset dn_sel", 32'(dn_sel), 32'd0);
    chk("R6 reset up_ready_out", 32'(up_ready_out), 32'd1);
    chk("R8 reset up_resp", 32'(up_resp), 32'd0);
  endtask

  task automatic t_word_write();
    xfer(1, 32'h4000_0010, 3'b010, 32'hA1B2_C3D4, 2, 0);
    chk("R1 word strobes", 32'(r_strb), 32'hF);
    chk("R7 write data all lanes", r_wdata, 32'hA1B2_C3D4);
    chk("R10 registered address", r_addr, 32'h4000_0010);
    chk("R6 access cycles with 2 waits", r_acc, 32'd3);
    chk("R6 setup before access", 32'(r_order_ok), 32'd1);
    chk("R6 ready low while selected", 32'(r_rdy_low_ok), 32'd1);
    chk("R6 stable over access", 32'(r_stable_ok), 32'd1);
    chk("R6 okay response", 32'(r_resp_end), 32'd0);
  endtask

  task automatic t_half_writes();
    for (int k = 0; k < 2; k++) begin
      xfer(1, 32'h4000_0020 + 32'(2 * k), 3'b001, 32'h1357_9BDF, 0, 0);
      chk("R2 halfword strobes", 32'(r_strb), 32'(exp_strb(3'b001, 2'(2 * k))));
      chk("R10 direction registered", 32'(r_setup_wr), 32'd1);
    end
  endtask

  task automatic t_byte_writes();
    for (int k = 0; k < 4; k++) begin
      xfer(1, 32'h4000_0030 + 32'(k), 3'b000, 32'h0F1E_2D3C + 32'(k), 1, 0);
      chk("R3 byte strobes", 32'(r_strb), 32'(exp_strb(3'b000, 2'(k))));
      chk("R7 byte write data", r_wdata, 32'h0F1E_2D3C + 32'(k));
    end
  endtask

  task automatic t_read();
    dn_rdata = 32'h8899_AABB;
    xfer(0, 32'h4000_0042, 3'b000, 32'h0, 1, 0);
    chk("R4 read strobes", 32'(r_strb), 32'h0);
    chk("R4 read direction", 32'(r_setup_wr), 32'd0);
    chk("R4 full word returned", r_rdata_end, 32'h8899_AABB);
  endtask

  task automatic t_ignored();
    bit quiet = 1;
    @(negedge clk);
    up_sel = 1; up_trans = 2'b00; gate = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dn_sel || !up_ready_out) quiet = 0;
      if (i == 1) up_trans = 2'b01;
      if (i == 3) begin up_trans = 2'b10; gate = 0; end
    end
    up_sel = 0; up_trans = 2'b00; gate = 1;
    @(negedge clk);
    if (dn_sel) quiet = 0;
    chk("R5 idle/busy/not-ready ignored", 32'(quiet), 32'd1);
    xfer(1, 32'h4000_0053, 3'b000, 32'h5555_AAAA, 0, 0);
    chk("R5 next transfer unaffected", 32'(r_strb), 32'h8);
  endtask

  task automatic t_slave_error();
    xfer(1, 32'h4000_0060, 3'b010, 32'hFFFF_0000, 1, 1);
    chk("R8 first error cycle", 32'(r_err1_seen), 32'd1);
    chk("R8 final error cycle", 32'(r_resp_end), 32'd1);
    xfer(1, 32'h4000_0064, 3'b001, 32'h1234_5678, 0, 0);
    chk("R8 recovers okay", 32'(r_resp_end), 32'd0);
  endtask

  task automatic t_bad_size();
    xfer(1, 32'h4000_0070, 3'b011, 32'h0, 0, 0);
    chk("R9 no peripheral access", 32'(r_any_sel), 32'd0);
    chk("R9 first error cycle", 32'(r_err1_seen), 32'd1);
    chk("R9 final error cycle", 32'(r_resp_end), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_word_write();
    t_half_writes();
    t_byte_writes();
    t_read();
    t_ignored();
    t_slave_error();
    t_bad_size();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule